// File: doc/BRIEF.md
# Load Driver Control and Fault Register

This block is a single 8-bit control and status register for an external load driver built from two switch transistors. Software uses it to turn on the main driver transistor and the series-resistor transistor, and to start an open-load test. Hardware fault inputs for a shorted output and for an open load set two sticky flags. Software clears a flag by writing a one to it. Each clear also moves the main driver enable as a side effect: clearing the short flag turns the driver back on, and clearing the open-load flag turns it off.

The register is reached over a simple synchronous bus. Writes take effect at the next clock edge. Reads are combinational and return zero at any address other than the register's own. The block drives the two transistor gate enables, with the safety gating applied. Analog sensing is done elsewhere, and faults arrive as digital pulses or levels on `short_det` and `open_det`.

Top module: `ldrv_ctl_reg`

## Requirements
- R1: After synchronous reset, the register reads 0x00 and both gate enables are low.
- R2: A write to address 0x05 loads bit7 (main driver enable), bit6 (open-load test enable) and bit5 (resistor path enable) from the write data, unless R5 or R6 overrides bit7. Bits 4 to 2 always read zero.
- R3: A read at any address other than 0x05 returns 0x00. A write to any other address leaves the register unchanged.
- R4: A high `short_det` sets the short flag (bit1), and a high `open_det` sets the open-load flag (bit0), at the next clock edge. A set flag stays set until it is cleared.
- R5: Writing a one to bit1 clears the short flag and sets the main driver enable, whatever write-data bit7 holds.
- R6: Writing a one to bit0 clears the open-load flag and clears the main driver enable, whatever write-data bit7 holds.
- R7: Writing a zero to a flag bit leaves that flag unchanged.
- R8: When a fault input is high in the same cycle as a clearing write to its flag, the flag stays set. The enable side effect of the write still applies.
- R9: With the test bit clear and the short flag clear, `gate_t2_en` equals the main enable and `gate_t1_en` equals the resistor enable.
- R10: While the open-load test bit is set, both gate enables are low.
- R11: While the short flag is set, both gate enables are low.
- R12: A write with both bit1 and bit0 set clears both flags and leaves the main driver enable cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register bus address |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data |
| short_det | input | 1 | Short-to-supply or short-to-ground detected |
| open_det | input | 1 | Open load detected |
| gate_t1_en | output | 1 | Enable for the series-resistor transistor |
| gate_t2_en | output | 1 | Enable for the main driver transistor |

## Verification
The bench writes every one of the 256 data values from each of the four starting flag states, so it covers every combination of enable bits and clear bits. A design that let write-data bit7 win over a clear side effect, or that let the short-flag clear win over the open-load clear, gives a wrong readback or gate value there. Directed cases place a fault pulse in the same cycle as its clear: a design that lets the clear win drops the flag and turns the gates back on while the fault is still present. Writes and reads at a neighbouring address catch a decoder that ignores bits of the address.

// File: rtl/ldrv_pkg.sv
package ldrv_pkg;

    localparam int DATA_W = 8;

    // Bit positions that software decodes.
    localparam int BIT_MAIN = 7;
    localparam int BIT_TEST = 6;
    localparam int BIT_RES  = 5;
    localparam int BIT_OC   = 1;
    localparam int BIT_OL   = 0;

    localparam int NUM_FLAGS = 2;
    localparam int FLAG_OC   = 1;
    localparam int FLAG_OL   = 0;

    typedef struct packed {
        logic main_en;
        logic test_en;
        logic res_en;
    } ctl_t;

    typedef struct packed {
        logic oc;
        logic ol;
    } flags_t;

    typedef struct packed {
        logic t1;
        logic t2;
    } gates_t;

    function automatic logic [DATA_W-1:0] pack_view(ctl_t c, flags_t f);
        logic [DATA_W-1:0] v;
        v           = '0;
        v[BIT_MAIN] = c.main_en;
        v[BIT_TEST] = c.test_en;
        v[BIT_RES]  = c.res_en;
        v[BIT_OC]   = f.oc;
        v[BIT_OL]   = f.ol;
        return v;
    endfunction

    function automatic gates_t gate_of(ctl_t c, flags_t f);
        gates_t g;
        logic   allow;
        allow = !c.test_en && !f.oc;
        g.t1  = c.res_en  && allow;
        g.t2  = c.main_en && allow;
        return g;
    endfunction

endpackage

// File: rtl/ldrv_fault_flag.sv
module ldrv_fault_flag (
    input  logic clk,
    input  logic rst,
    input  logic det,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst)
            flag <= 1'b0;
        else if (det)
            flag <= 1'b1;
        else if (clr)
            flag <= 1'b0;
    end

    a_r4_set_on_fault: assert property (@(posedge clk) disable iff (rst)
        det |=> flag);
    a_r8_clear_without_fault: assert property (@(posedge clk) disable iff (rst)
        (clr && !det) |=> !flag);
    a_r7_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        (!clr && !det) |=> $stable(flag));
endmodule

// File: rtl/ldrv_ctl_bits.sv
module ldrv_ctl_bits
    import ldrv_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [DATA_W-1:0] wdata,
    output ctl_t              ctl
);
    logic clr_oc_w, clr_ol_w;
    assign clr_oc_w = wdata[BIT_OC];
    assign clr_ol_w = wdata[BIT_OL];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl <= '0;
        end else if (wr) begin
            ctl.test_en <= wdata[BIT_TEST];
            ctl.res_en  <= wdata[BIT_RES];
            if (clr_ol_w)
                ctl.main_en <= 1'b0;
            else if (clr_oc_w)
                ctl.main_en <= 1'b1;
            else
                ctl.main_en <= wdata[BIT_MAIN];
        end
    end

    a_r5_oc_clear_turns_on: assert property (@(posedge clk) disable iff (rst)
        (wr && clr_oc_w && !clr_ol_w) |=> ctl.main_en);
    a_r6_ol_clear_turns_off: assert property (@(posedge clk) disable iff (rst)
        (wr && clr_ol_w) |=> !ctl.main_en);
    a_r3_no_write_holds: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(ctl));
endmodule

// File: rtl/ldrv_ctl_reg.sv
module ldrv_ctl_reg
    import ldrv_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = 8'h05
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              short_det,
    input  logic              open_det,
    output logic              gate_t1_en,
    output logic              gate_t2_en
);
    logic                 hit;
    logic                 wr;
    ctl_t                 ctl;
    flags_t               flags;
    gates_t               gates;
    logic [NUM_FLAGS-1:0] det_vec;
    logic [NUM_FLAGS-1:0] clr_vec;
    logic [NUM_FLAGS-1:0] flag_vec;

    assign hit = (bus_addr == REG_ADDR);
    assign wr  = hit && bus_we;

    assign det_vec[FLAG_OC] = short_det;
    assign det_vec[FLAG_OL] = open_det;
    assign clr_vec[FLAG_OC] = wr && bus_wdata[BIT_OC];
    assign clr_vec[FLAG_OL] = wr && bus_wdata[BIT_OL];

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        ldrv_fault_flag u_flag (
            .clk  (clk),
            .rst  (rst),
            .det  (det_vec[i]),
            .clr  (clr_vec[i]),
            .flag (flag_vec[i])
        );
    end

    assign flags.oc = flag_vec[FLAG_OC];
    assign flags.ol = flag_vec[FLAG_OL];

    ldrv_ctl_bits u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr    (wr),
        .wdata (bus_wdata),
        .ctl   (ctl)
    );

    assign gates      = gate_of(ctl, flags);
    assign gate_t1_en = gates.t1;
    assign gate_t2_en = gates.t2;
    assign bus_rdata  = hit ? pack_view(ctl, flags) : '0;

    a_r3_miss_reads_zero: assert property (@(posedge clk) disable iff (rst)
        !hit |-> (bus_rdata == '0));
    a_r10_test_blocks_gates: assert property (@(posedge clk) disable iff (rst)
        ctl.test_en |-> (!gate_t1_en && !gate_t2_en));
    a_r11_short_blocks_gates: assert property (@(posedge clk) disable iff (rst)
        flags.oc |-> (!gate_t1_en && !gate_t2_en));
    a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
        bus_rdata[4:2] == 3'b000);
endmodule

// File: tb/ldrv_ctl_reg_bench.sv
module ldrv_ctl_reg_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [7:0] bus_addr = 8'h05;
    logic       bus_we = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       short_det = 1'b0;
    logic       open_det = 1'b0;
    logic       gate_t1_en, gate_t2_en;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    ldrv_ctl_reg u_ldrv_ctl_reg (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .short_det(short_det),
        .open_det(open_det), .gate_t1_en(gate_t1_en), .gate_t2_en(gate_t2_en)
    );

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bus_we = 1'b0; short_det = 1'b0; open_det = 1'b0;
        bus_addr = 8'h05;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic write(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = 8'h05;
    endtask

    task automatic fault(logic s, logic o);
        @(negedge clk);
        short_det = s; open_det = o;
        @(negedge clk);
        short_det = 1'b0; open_det = 1'b0;
    endtask

    initial begin
        do_reset();
        // R1 reset state
        check("R1 rdata", bus_rdata, 8'h00);
        check("R1 gates", {6'b0, gate_t1_en, gate_t2_en}, 8'h00);

        // R4 fault sets flags
        fault(1'b1, 1'b0);
        check("R4 short flag", bus_rdata, 8'h02);
        @(negedge clk);
        check("R4 short flag sticky", bus_rdata, 8'h02);
        fault(1'b0, 1'b1);
        check("R4 open flag", bus_rdata, 8'h03);

        // R3 other address
        do_reset();
        write(8'h04, 8'hE0);
        check("R3 miss write ignored", bus_rdata, 8'h00);
        write(8'h05, 8'hA0);
        bus_addr = 8'h04; #1;
        check("R3 miss read zero", bus_rdata, 8'h00);
        bus_addr = 8'h85; #1;
        check("R3 high addr bit miss", bus_rdata, 8'h00);
        bus_addr = 8'h05; #1;
        check("R9 gates follow enables", {6'b0, gate_t1_en, gate_t2_en}, 8'h03);

        // R8 fault coincident with clear
        do_reset();
        fault(1'b1, 1'b0);
        @(negedge clk);
        bus_we = 1'b1; bus_wdata = 8'h22; short_det = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; short_det = 1'b0;
        check("R8 short flag kept, main on", bus_rdata, 8'hA2);
        check("R8 R11 gates off", {6'b0, gate_t1_en, gate_t2_en}, 8'h00);
        do_reset();
        fault(1'b0, 1'b1);
        @(negedge clk);
        bus_we = 1'b1; bus_wdata = 8'h81; open_det = 1'b1;
        @(negedge clk);
        bus_we = 1'b0; open_det = 1'b0;
        check("R8 open flag kept, main off", bus_rdata, 8'h01);

        // Exhaustive sweep: R2 R5 R6 R7 R9 R10 R11 R12
        for (int st = 0; st < 4; st++) begin
            for (int w = 0; w < 256; w++) begin
                logic [7:0] d;
                logic oc0, ol0, m, t, r, oc1, ol1, g1, g2;
                d = 8'(w);
                oc0 = st[1]; ol0 = st[0];
                do_reset();
                if (oc0 || ol0) fault(oc0, ol0);
                write(8'h05, d);
                m = d[7];
                if (d[1]) m = 1'b1;
                if (d[0]) m = 1'b0;
                t = d[6]; r = d[5];
                oc1 = oc0 && !d[1];
                ol1 = ol0 && !d[0];
                g1 = r && !t && !oc1;
                g2 = m && !t && !oc1;
                check("R2 R5 R6 R7 R12 readback", bus_rdata,
                      {m, t, r, 3'b000, oc1, ol1});
                check("R9 R10 R11 gates", {6'b0, gate_t1_en, gate_t2_en},
                      {6'b0, g1, g2});
            end
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule